// File: doc/BRIEF.md
# Atomic Placement Controller

This block chooses where a single atomic read-modify-write is carried out. A request names an atomic class and whether its target is write-back cacheable. One cycle later the block samples the local data cache lookup state and the cluster snoop result. It then sends the atomic down one of four routes:

- it runs it locally as a near atomic;
- it hands it to the shared last-level memory system;
- it forwards it to the interconnect;
- it completes it with an abort.

A per-class preference can ask for one local fill before a near attempt. If that filled line is lost before the atomic runs, the request falls back to the far path and is not refilled.

The block takes one request at a time through a ready/valid handshake. The outcome is returned as a one-cycle pulse carrying a 2-bit code and a flag that says whether the line should be allocated in the L3. The arithmetic, the cache arrays and the coherence protocol are outside this block. They appear only as plain inputs.

Top module: `amo_route_ctrl`

## Requirements
- R1: A cacheable atomic whose lookup state is unique (l1_state 2'b10) raises near_exec for exactly one cycle. It issues no fill and completes with resp_code 2'b00 (near).
- R2: A cacheable atomic whose lookup is invalid (2'b00, and 2'b11 is treated the same) or shared (2'b01) goes far when no near preference applies. It completes with resp_code 2'b01 (far to interconnect) when snoop_hit is 0 and cfg_ic_atomics is 1.
- R3: A far cacheable atomic completes with resp_code 2'b10 (far to shared level) when snoop_hit is 1 or cfg_ic_atomics is 0. resp_l3_alloc then equals cfg_l3_present. For every other outcome resp_l3_alloc is 0.
- R4: A cacheable, non-unique atomic whose class bit in cfg_near_pref (bit index = req_class) is 1 produces exactly one single-cycle fill_req. When fill_done arrives, the atomic runs near and completes with resp_code 2'b00.
- R5: If fill_lost arrives while the fill is outstanding, the atomic takes the far route of R2/R3 with no further fill. fill_lost wins when fill_done arrives in the same cycle.
- R6: A non-cacheable atomic (req_cacheable 0) ignores l1_state and cfg_near_pref. It never fills and never runs near. It completes with 2'b01 when cfg_ic_atomics is 1 and with 2'b11 (abort) otherwise.
- R7: req_ready is 1 only while idle. After a request is accepted, it stays 0 until the response pulse has ended.
- R8: resp_valid is a one-cycle pulse. On paths without a fill it is high in the cycle after the third rising edge, counting the edge that accepted the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Atomic request present |
| req_ready | output | 1 | Block idle and able to accept |
| req_class | input | CLS_W | Atomic class index |
| req_cacheable | input | 1 | 1 = write-back cacheable, 0 = device or non-cacheable |
| l1_state | input | 2 | Lookup state: 00 invalid, 01 shared, 10 unique, 11 invalid; sampled one cycle after acceptance |
| snoop_hit | input | 1 | Line present elsewhere in cluster; sampled one cycle after acceptance |
| cfg_ic_atomics | input | 1 | Interconnect executes atomics |
| cfg_l3_present | input | 1 | Shared level has an L3 |
| cfg_near_pref | input | NUM_CLASSES | Per-class request for a near attempt |
| fill_req | output | 1 | One-cycle fill request to the local cache |
| fill_done | input | 1 | Fill installed and usable |
| fill_lost | input | 1 | Filled line lost before execution |
| near_exec | output | 1 | Strobe: run atomic locally this cycle |
| resp_valid | output | 1 | Outcome pulse |
| resp_code | output | 2 | 00 near, 01 far interconnect, 10 far shared level, 11 abort |
| resp_l3_alloc | output | 1 | Allocate line in L3 for a shared-level outcome |

## Verification
The bench goes after four corner cases:

- **Shared line versus unique line.** A design that treated a shared line as unique would run near with no fill and report 00 where far was due.
- **fill_lost and fill_done together.** A design that let done win would execute near on a line it no longer holds. A design that refilled after a loss would show two fill pulses.
- **Device memory with near preference and a unique lookup.** A design that consulted the cache for such targets would run near or fill.
- **Device memory without interconnect support.** A design that missed the abort would report a far route instead.

Random traffic over classes, configurations and snoop results also exposes any mix-up between the two far codes and any stray L3 allocation flag.

// File: rtl/amo_route_pkg.sv
package amo_route_pkg;

    typedef enum logic [1:0] {
        L1_INV = 2'b00,
        L1_SHR = 2'b01,
        L1_UNQ = 2'b10,
        L1_RSV = 2'b11
    } l1_state_e;

    typedef enum logic [1:0] {
        RT_NEAR    = 2'b00,
        RT_FAR_IC  = 2'b01,
        RT_FAR_SHR = 2'b10,
        RT_ABORT   = 2'b11
    } route_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_FILL_WAIT,
        ST_EXEC_NEAR,
        ST_ROUTE_FAR,
        ST_RESPOND
    } fsm_state_e;

    // Far-path destination for an atomic that will not run locally.
    function automatic route_e far_route(input logic cacheable,
                                         input logic snoop_hit,
                                         input logic ic_ok);
        if (!cacheable)
            return ic_ok ? RT_FAR_IC : RT_ABORT;
        else if (snoop_hit || !ic_ok)
            return RT_FAR_SHR;
        else
            return RT_FAR_IC;
    endfunction

endpackage

// File: rtl/amo_pref_sel.sv
module amo_pref_sel #(
    parameter int NUM_CLASSES = 4,
    parameter int CLS_W       = 2
) (
    input  logic [CLS_W-1:0]       cls,
    input  logic [NUM_CLASSES-1:0] pref,
    output logic                   pref_hit
);
    logic [NUM_CLASSES-1:0] sel;

    for (genvar k = 0; k < NUM_CLASSES; k++) begin : g_cls
        assign sel[k] = (cls == CLS_W'(k)) & pref[k];
    end

    assign pref_hit = |sel;
endmodule

// File: rtl/amo_route_fsm.sv
module amo_route_fsm
    import amo_route_pkg::*;
#(
    parameter int CLS_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [CLS_W-1:0] req_class,
    input  logic             req_cacheable,
    input  logic [1:0]       l1_state,
    input  logic             snoop_hit,
    input  logic             pref_hit,
    input  logic             cfg_ic_atomics,
    input  logic             fill_done,
    input  logic             fill_lost,
    output logic             req_ready,
    output logic [CLS_W-1:0] cls_q,
    output logic             fill_req,
    output logic             near_exec,
    output logic             resp_valid,
    output logic             out_load,
    output route_e           out_code
);
    fsm_state_e state, state_d;
    logic       cach_q;
    logic       snoop_q;
    logic       fill_first;

    always_comb begin
        state_d  = state;
        out_load = 1'b0;
        out_code = RT_NEAR;
        unique case (state)
            ST_IDLE:
                if (req_valid) state_d = ST_LOOKUP;
            ST_LOOKUP:
                if (!cach_q)
                    state_d = ST_ROUTE_FAR;
                else if (l1_state == L1_UNQ)
                    state_d = ST_EXEC_NEAR;
                else if (pref_hit)
                    state_d = ST_FILL_WAIT;
                else
                    state_d = ST_ROUTE_FAR;
            ST_FILL_WAIT:
                if (fill_lost)
                    state_d = ST_ROUTE_FAR;
                else if (fill_done)
                    state_d = ST_EXEC_NEAR;
            ST_EXEC_NEAR: begin
                out_load = 1'b1;
                out_code = RT_NEAR;
                state_d  = ST_RESPOND;
            end
            ST_ROUTE_FAR: begin
                out_load = 1'b1;
                out_code = far_route(cach_q, snoop_q, cfg_ic_atomics);
                state_d  = ST_RESPOND;
            end
            ST_RESPOND:
                state_d = ST_IDLE;
            default:
                state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            cls_q      <= '0;
            cach_q     <= 1'b0;
            snoop_q    <= 1'b0;
            fill_first <= 1'b0;
        end else begin
            state      <= state_d;
            fill_first <= (state == ST_LOOKUP) && (state_d == ST_FILL_WAIT);
            if (state == ST_IDLE && req_valid) begin
                cls_q  <= req_class;
                cach_q <= req_cacheable;
            end
            if (state == ST_LOOKUP)
                snoop_q <= snoop_hit;
        end
    end

    assign req_ready  = (state == ST_IDLE);
    assign fill_req   = fill_first;
    assign near_exec  = (state == ST_EXEC_NEAR);
    assign resp_valid = (state == ST_RESPOND);
endmodule

// File: rtl/amo_resp_stage.sv
module amo_resp_stage
    import amo_route_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  route_e     code_d,
    input  logic       cfg_l3_present,
    output logic [1:0] resp_code,
    output logic       resp_l3_alloc
);
    route_e code_q;
    logic   l3_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= RT_NEAR;
            l3_q   <= 1'b0;
        end else if (load) begin
            code_q <= code_d;
            l3_q   <= (code_d == RT_FAR_SHR) && cfg_l3_present;
        end
    end

    assign resp_code     = code_q;
    assign resp_l3_alloc = l3_q;
endmodule

// File: rtl/amo_route_ctrl.sv
module amo_route_ctrl
    import amo_route_pkg::*;
#(
    parameter  int NUM_CLASSES = 4,
    localparam int CLS_W       = (NUM_CLASSES > 1) ? $clog2(NUM_CLASSES) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [CLS_W-1:0]       req_class,
    input  logic                   req_cacheable,
    input  logic [1:0]             l1_state,
    input  logic                   snoop_hit,
    input  logic                   cfg_ic_atomics,
    input  logic                   cfg_l3_present,
    input  logic [NUM_CLASSES-1:0] cfg_near_pref,
    output logic                   fill_req,
    input  logic                   fill_done,
    input  logic                   fill_lost,
    output logic                   near_exec,
    output logic                   resp_valid,
    output logic [1:0]             resp_code,
    output logic                   resp_l3_alloc
);
    logic [CLS_W-1:0] cls_q;
    logic             pref_hit;
    logic             out_load;
    route_e           out_code;

    amo_pref_sel #(.NUM_CLASSES(NUM_CLASSES), .CLS_W(CLS_W)) u_pref (
        .cls      (cls_q),
        .pref     (cfg_near_pref),
        .pref_hit (pref_hit)
    );

    amo_route_fsm #(.CLS_W(CLS_W)) u_fsm (
        .clk            (clk),
        .rst            (rst),
        .req_valid      (req_valid),
        .req_class      (req_class),
        .req_cacheable  (req_cacheable),
        .l1_state       (l1_state),
        .snoop_hit      (snoop_hit),
        .pref_hit       (pref_hit),
        .cfg_ic_atomics (cfg_ic_atomics),
        .fill_done      (fill_done),
        .fill_lost      (fill_lost),
        .req_ready      (req_ready),
        .cls_q          (cls_q),
        .fill_req       (fill_req),
        .near_exec      (near_exec),
        .resp_valid     (resp_valid),
        .out_load       (out_load),
        .out_code       (out_code)
    );

    amo_resp_stage u_resp (
        .clk            (clk),
        .rst            (rst),
        .load           (out_load),
        .code_d         (out_code),
        .cfg_l3_present (cfg_l3_present),
        .resp_code      (resp_code),
        .resp_l3_alloc  (resp_l3_alloc)
    );
endmodule

// File: rtl/amo_route_chk.sv
module amo_route_chk (
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic       req_ready,
    input logic       req_cacheable,
    input logic       cfg_ic_atomics,
    input logic       cfg_l3_present,
    input logic       fill_req,
    input logic       near_exec,
    input logic       resp_valid,
    input logic [1:0] resp_code,
    input logic       resp_l3_alloc
);
    logic busy_q;
    logic cach_q;
    logic fill_seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q      <= 1'b0;
            cach_q      <= 1'b0;
            fill_seen_q <= 1'b0;
        end else begin
            if (req_valid && req_ready) begin
                busy_q      <= 1'b1;
                cach_q      <= req_cacheable;
                fill_seen_q <= 1'b0;
            end else begin
                if (resp_valid) busy_q <= 1'b0;
                if (fill_req) fill_seen_q <= 1'b1;
            end
        end
    end

    // R7: only one request in flight
    p_single_accept_r7: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready |=> !req_ready);
    p_busy_not_ready_r7: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> !req_ready);
    // R8: outcome is a pulse
    p_resp_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        resp_valid |=> !resp_valid);
    // R1: local execution is followed by a near outcome
    p_exec_near_r1: assert property (@(posedge clk) disable iff (rst)
        near_exec |=> resp_valid && resp_code == 2'b00);
    // R4 / R5: at most one fill, as a pulse
    p_fill_once_r4: assert property (@(posedge clk) disable iff (rst)
        fill_req |-> !fill_seen_q);
    p_fill_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        fill_req |=> !fill_req);
    // R6: device targets never fill or run near
    p_device_no_fill_r6: assert property (@(posedge clk) disable iff (rst)
        fill_req |-> cach_q);
    p_device_route_r6: assert property (@(posedge clk) disable iff (rst)
        resp_valid && !cach_q |-> resp_code == 2'b01 || resp_code == 2'b11);
    p_abort_cause_r6: assert property (@(posedge clk) disable iff (rst)
        resp_valid && resp_code == 2'b11 |-> !cach_q && !cfg_ic_atomics);
    // R3: allocation flag only with a shared-level outcome and an L3
    p_l3_alloc_r3: assert property (@(posedge clk) disable iff (rst)
        resp_valid && resp_l3_alloc |-> resp_code == 2'b10 && cfg_l3_present);
endmodule

bind amo_route_ctrl amo_route_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .req_cacheable  (req_cacheable),
    .cfg_ic_atomics (cfg_ic_atomics),
    .cfg_l3_present (cfg_l3_present),
    .fill_req       (fill_req),
    .near_exec      (near_exec),
    .resp_valid     (resp_valid),
    .resp_code      (resp_code),
    .resp_l3_alloc  (resp_l3_alloc)
);

// File: tb/tb_amo_route_ctrl.sv
module tb_amo_route_ctrl;
    localparam int NC = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_class = '0;
    logic          req_cacheable = 1'b0;
    logic [1:0]    l1_state = 2'b00;
    logic          snoop_hit = 1'b0;
    logic          cfg_ic_atomics = 1'b0;
    logic          cfg_l3_present = 1'b0;
    logic [NC-1:0] cfg_near_pref = '0;
    logic          fill_req;
    logic          fill_done = 1'b0;
    logic          fill_lost = 1'b0;
    logic          near_exec;
    logic          resp_valid;
    logic [1:0]    resp_code;
    logic          resp_l3_alloc;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    amo_route_ctrl #(.NUM_CLASSES(NC)) dut (.*);

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_code(bit cach, logic [1:0] l1, bit snp,
                                    bit pref, bit ic, int fmode);
        if (!cach) return ic ? 1 : 3;
        if (l1 == 2'b10) return 0;
        if (pref && fmode == 0) return 0;
        if (snp || !ic) return 2;
        return 1;
    endfunction

    function automatic string tag_of(bit cach, logic [1:0] l1, bit pref,
                                     int fmode, int code);
        if (!cach) return "R6";
        if (l1 == 2'b10) return "R1";
        if (pref) return (fmode == 0) ? "R4" : "R5";
        return (code == 2) ? "R3" : "R2";
    endfunction

    // fmode: 0 fill_done, 1 fill_lost, 2 both in the same cycle
    task automatic run_op(input logic [1:0] cls, input bit cach,
                          input logic [1:0] l1, input bit snp, input int fmode);
        int  nfill = 0, nnear = 0, resp_at = -1, fill_at = -1;
        int  code_seen = 0, l3_seen = 0;
        bit  pref = cfg_near_pref[cls];
        int  ec = exp_code(cach, l1, snp, pref, cfg_ic_atomics, fmode);
        bit  fill_path = cach && l1 != 2'b10 && pref;
        string t = tag_of(cach, l1, pref, fmode, ec);

        check(req_ready == 1'b1, "R7", "ready while idle", int'(req_ready), 1);
        req_class = cls; req_cacheable = cach; l1_state = l1; snoop_hit = snp;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R7", "ready after accept", int'(req_ready), 0);
        for (int i = 0; i < 40; i++) begin
            fill_done = 1'b0; fill_lost = 1'b0;
            if (fill_req) begin nfill++; fill_at = i + 2; end
            if (near_exec) nnear++;
            if (resp_valid) begin
                resp_at = i; code_seen = resp_code; l3_seen = resp_l3_alloc;
                break;
            end
            if (i != 0 && resp_at < 0 && !req_ready && i == fill_at) begin
                fill_done = (fmode != 1);
                fill_lost = (fmode != 0);
            end
            check(i == 0 || req_ready == 1'b0, "R7", "ready while busy",
                  int'(req_ready), 0);
            @(negedge clk);
        end
        fill_done = 1'b0; fill_lost = 1'b0;
        check(resp_at >= 0 && code_seen == ec, t, "resp_code", code_seen, ec);
        check(l3_seen == ((ec == 2) ? int'(cfg_l3_present) : 0), "R3",
              "l3 alloc", l3_seen, (ec == 2) ? int'(cfg_l3_present) : 0);
        check(nnear == ((ec == 0) ? 1 : 0), t, "near_exec count",
              nnear, (ec == 0) ? 1 : 0);
        check(nfill == (fill_path ? 1 : 0), t, "fill count",
              nfill, fill_path ? 1 : 0);
        if (!fill_path)
            check(resp_at == 2, "R8", "response cycle", resp_at, 2);
        @(negedge clk);
        check(resp_valid == 1'b0, "R8", "pulse width", int'(resp_valid), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready == 1'b1, "R7", "reset ready", int'(req_ready), 1);
        check(resp_valid == 1'b0, "R8", "reset resp", int'(resp_valid), 0);
        check(fill_req == 1'b0 && near_exec == 1'b0, "R4", "reset strobes",
              int'(fill_req) + int'(near_exec), 0);

        // Directed corner cases
        cfg_ic_atomics = 1; cfg_l3_present = 1; cfg_near_pref = '0;
        run_op(2'd0, 1, 2'b10, 0, 0);           // R1 unique hit
        run_op(2'd1, 1, 2'b01, 0, 0);           // R2 shared, far ic
        run_op(2'd1, 1, 2'b11, 0, 0);           // R2 reserved code = invalid
        run_op(2'd2, 1, 2'b00, 1, 0);           // R3 snoop hit
        cfg_ic_atomics = 0; cfg_l3_present = 0;
        run_op(2'd2, 1, 2'b00, 0, 0);           // R3 no ic support, no L3
        cfg_near_pref = 4'b0100; cfg_ic_atomics = 1;
        run_op(2'd2, 1, 2'b01, 0, 0);           // R4 fill then near
        run_op(2'd2, 1, 2'b00, 0, 1);           // R5 lost
        run_op(2'd2, 1, 2'b00, 1, 2);           // R5 lost and done together
        run_op(2'd3, 1, 2'b00, 0, 0);           // R2 other class not preferred
        cfg_near_pref = '1;
        run_op(2'd2, 0, 2'b10, 0, 0);           // R6 device to interconnect
        cfg_ic_atomics = 0;
        run_op(2'd1, 0, 2'b10, 1, 0);           // R6 device abort

        // Constrained random traffic
        for (int n = 0; n < 300; n++) begin
            cfg_ic_atomics = 1'($urandom);
            cfg_l3_present = 1'($urandom);
            cfg_near_pref  = NC'($urandom);
            run_op(2'($urandom), ($urandom % 4) != 0, 2'($urandom),
                   1'($urandom), int'($urandom % 3));
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule